// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns a decoded operand specifier into the 24-bit byte address of a memory operand. It also handles the two specifier kinds that need no memory address: a register operand and an immediate operand. The instruction decoder supplies a mode code, an operand size, a register selector, the contents of the eight 32-bit address registers, the address of the next instruction, and the extension word of the instruction. One cycle after `start`, the unit returns the address, or the register or immediate operand value, together with a one-cycle `done` pulse.

Auto-increment and auto-decrement modes also present a register write-back (index and new 32-bit value) in the same cycle as `done`. The caller commits that write-back to the register file. The pointer-through-memory mode takes two steps. First the unit raises a read request for a pointer in the lowest 256 bytes of the address space. It holds that request until the memory answers with `rd_valid`. It then reports the returned pointer as the address.

Top module: `ea_unit`

## Requirements
- R1: Mode 0 (register operand) sets `opnd_is_reg`. `opnd_data` then holds the selected register view, zero-extended. The low three bits of `reg_sel` pick the 32-bit register. Size 0 (byte) gives bits 15:8 when `reg_sel[3]`=0 and bits 7:0 when it is 1. Size 1 (word) gives bits 15:0 when `reg_sel[3]`=0 and bits 31:16 when it is 1. Size 2 (long) gives all 32 bits.
- R2: Mode 1 (register indirect) gives `ea` equal to the low 24 bits of the selected register.
- R3: Mode 2 adds the sign-extended `ext[15:0]` to the register, and mode 3 adds `ext[23:0]`. In both modes `ea` is the low 24 bits of the sum.
- R4: Mode 4 (post-increment) gives `ea` equal to the original low 24 bits of the register. It also raises `wb_en` with `wb_idx` set to the register and `wb_data` set to the register plus the operand size: 1, 2 or 4 for size codes 0, 1 and 2.
- R5: Mode 5 (pre-decrement) computes the register minus the operand size. `wb_data` carries that value, `ea` carries its low 24 bits, and `wb_en` is raised.
- R6: Mode 6 gives `ea` = 0xFFFF00 | `ext[7:0]`. Mode 7 gives the sign-extended `ext[15:0]`. Mode 8 gives `ext[23:0]`.
- R7: Mode 9 (immediate) sets `opnd_is_imm`, with `opnd_data` equal to `ext` masked to 8, 16 or 32 bits by size code 0, 1 or 2. `opnd_is_reg` and `opnd_is_imm` are never both high.
- R8: Modes 10 and 11 give `ea` = `pc` plus the sign-extended `ext[7:0]` or `ext[15:0]`, truncated to 24 bits.
- R9: Mode 12 (pointer through memory) raises `rd_req` one cycle after `start`, with `rd_addr` equal to the zero-extended `ext[7:0]`. The request and its address stay steady until `rd_valid` is high. In the cycle after that, `done` is high, `rd_req` is low, and `ea` equals `rd_data[23:0]`.
- R10: For every mode other than 12, `done` is high exactly in the cycle after an accepted `start`, and `wb_en` is high only in a cycle where `done` is high.
- R11: While a pointer read is outstanding, `start` is ignored: no `done` is produced and the outstanding result is unaffected.
- R12: During and right after reset, `done`, `rd_req` and `wb_en` are low and `ea` is zero.
- R13: Mode codes 13 to 15 give `done` with `ea` zero, both operand flags low and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an address computation |
| mode | input | 4 | Addressing mode code (0 to 12) |
| size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| reg_sel | input | 4 | Register index in bits 2:0, half select in bit 3 |
| rf_flat | input | 256 | Eight 32-bit address registers, register k at bits 32k+31:32k |
| pc | input | 24 | Address of the next instruction |
| ext | input | 32 | Instruction extension word |
| rd_valid | input | 1 | Pointer read data is valid |
| rd_data | input | 32 | Pointer read data |
| done | output | 1 | Result valid pulse |
| ea | output | 24 | Effective address |
| opnd_is_reg | output | 1 | Operand is a register |
| opnd_is_imm | output | 1 | Operand is an immediate |
| opnd_data | output | 32 | Register view or masked immediate |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 3 | Write-back register index |
| wb_data | output | 32 | Write-back value |
| rd_req | output | 1 | Pointer read request |
| rd_addr | output | 24 | Pointer read address |

## Verification
For every mode except 12, all results are registered once, so they appear with `done` exactly one clock after the edge that samples `start`. The driver samples `done` at the falling edge one cycle after it raised `start`, and the scoreboard monitor compares the queued expectation at that same falling edge. For mode 12, `rd_req` is checked one cycle after `start`. The bench then waits several cycles and fires a stray `start` that must produce nothing. The answer is driven next, and `done` with the returned pointer is expected one cycle after the `rd_valid` edge. Any `done` with an empty queue counts as a failure, so an early, late or extra pulse is caught.

// File: rtl/ea_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the effective address unit: mode codes, size codes
// and controller states. Mode code values are part of the decoder contract.
package ea_pkg;

    typedef enum logic [3:0] {
        AM_REG     = 4'd0,
        AM_IND     = 4'd1,
        AM_DSP16   = 4'd2,
        AM_DSP24   = 4'd3,
        AM_POSTINC = 4'd4,
        AM_PREDEC  = 4'd5,
        AM_ABS8    = 4'd6,
        AM_ABS16   = 4'd7,
        AM_ABS24   = 4'd8,
        AM_IMM     = 4'd9,
        AM_PCR8    = 4'd10,
        AM_PCR16   = 4'd11,
        AM_MEMPTR  = 4'd12
    } am_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } opsize_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ea_state_e;

endpackage

// File: rtl/ea_reg_view.sv
`timescale 1ns/1ps
// Register view selector.
// Unpacks the flat register file, picks one register by index and forms the
// byte, word or long view of it, zero-extended to the register width.
// Assumes REG_W is a multiple of 4 (byte = quarter, word = half).
module ea_reg_view #(
    parameter int REG_W = 32,
    parameter int NREGS = 8,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic [NREGS*REG_W-1:0] rf_flat,
    input  logic [IDX_W-1:0]       sel,
    input  logic                   half,
    input  logic [1:0]             size,
    output logic [REG_W-1:0]       reg_full,
    output logic [REG_W-1:0]       reg_view
);
    import ea_pkg::*;

    localparam int HW = REG_W / 2;
    localparam int BW = REG_W / 4;

    logic [REG_W-1:0] regs [NREGS];

    // Unpack the flat register file into an array.
    for (genvar g = 0; g < NREGS; g++) begin : g_unpack
        assign regs[g] = rf_flat[g*REG_W +: REG_W];
    end

    assign reg_full = regs[sel];

    // Form the sized view of the selected register.
    always_comb begin
        case (size)
            SZ_BYTE: reg_view = half ? {{(REG_W-BW){1'b0}}, reg_full[BW-1:0]}
                                     : {{(REG_W-BW){1'b0}}, reg_full[2*BW-1:BW]};
            SZ_WORD: reg_view = half ? {{(REG_W-HW){1'b0}}, reg_full[REG_W-1:HW]}
                                     : {{(REG_W-HW){1'b0}}, reg_full[HW-1:0]};
            default: reg_view = reg_full;
        endcase
    end

endmodule

// File: rtl/ea_addr_calc.sv
`timescale 1ns/1ps
// Address arithmetic, purely combinational.
// From the mode, size, selected register, next-instruction address and
// extension word it computes the candidate address, the operand class, the
// operand value and the auto-update write-back value.
// Assumes ADDR_W >= 16 and REG_W >= ADDR_W.
module ea_addr_calc #(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 32
) (
    input  logic [3:0]        mode,
    input  logic [1:0]        size,
    input  logic [REG_W-1:0]  reg_full,
    input  logic [REG_W-1:0]  reg_view,
    input  logic [ADDR_W-1:0] pc,
    input  logic [REG_W-1:0]  ext,
    output logic [ADDR_W-1:0] c_ea,
    output logic              c_is_reg,
    output logic              c_is_imm,
    output logic [REG_W-1:0]  c_opnd,
    output logic              c_wb,
    output logic [REG_W-1:0]  c_wb_val,
    output logic              c_memptr
);
    import ea_pkg::*;

    logic [REG_W-1:0]  step;
    logic [REG_W-1:0]  reg_inc;
    logic [REG_W-1:0]  reg_dec;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] sx8;
    logic [ADDR_W-1:0] sx16;
    logic [REG_W-1:0]  imm_m;

    // Operand size in bytes for auto-update modes.
    always_comb begin
        case (size)
            SZ_BYTE: step = REG_W'(1);
            SZ_WORD: step = REG_W'(2);
            default: step = REG_W'(4);
        endcase
    end

    assign reg_inc = reg_full + step;
    assign reg_dec = reg_full - step;
    assign base    = reg_full[ADDR_W-1:0];
    assign sx8     = {{(ADDR_W-8){ext[7]}}, ext[7:0]};
    assign sx16    = {{(ADDR_W-16){ext[15]}}, ext[15:0]};

    // Immediate masked to the operand size.
    always_comb begin
        case (size)
            SZ_BYTE: imm_m = {{(REG_W-8){1'b0}}, ext[7:0]};
            SZ_WORD: imm_m = {{(REG_W-16){1'b0}}, ext[15:0]};
            default: imm_m = ext;
        endcase
    end

    // Mode decode: address, class flags and write-back request.
    always_comb begin
        c_ea     = '0;
        c_is_reg = 1'b0;
        c_is_imm = 1'b0;
        c_opnd   = '0;
        c_wb     = 1'b0;
        c_wb_val = '0;
        c_memptr = 1'b0;
        case (mode)
            AM_REG: begin
                c_is_reg = 1'b1;
                c_opnd   = reg_view;
            end
            AM_IND:   c_ea = base;
            AM_DSP16: c_ea = base + sx16;
            AM_DSP24: c_ea = base + ext[ADDR_W-1:0];
            AM_POSTINC: begin
                c_ea     = base;
                c_wb     = 1'b1;
                c_wb_val = reg_inc;
            end
            AM_PREDEC: begin
                c_ea     = reg_dec[ADDR_W-1:0];
                c_wb     = 1'b1;
                c_wb_val = reg_dec;
            end
            AM_ABS8:  c_ea = {{(ADDR_W-8){1'b1}}, ext[7:0]};
            AM_ABS16: c_ea = sx16;
            AM_ABS24: c_ea = ext[ADDR_W-1:0];
            AM_IMM: begin
                c_is_imm = 1'b1;
                c_opnd   = imm_m;
            end
            AM_PCR8:   c_ea = pc + sx8;
            AM_PCR16:  c_ea = pc + sx16;
            AM_MEMPTR: c_memptr = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ea_ctrl.sv
`timescale 1ns/1ps
// Sequencer and output registers.
// Registers the computed result one cycle after start. For the pointer mode
// it raises a read request, waits for the response and then reports the
// returned pointer. start is ignored while a read is outstanding.
module ea_ctrl #(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        ptr_loc,
    input  logic [ADDR_W-1:0] c_ea,
    input  logic              c_is_reg,
    input  logic              c_is_imm,
    input  logic [REG_W-1:0]  c_opnd,
    input  logic              c_wb,
    input  logic [REG_W-1:0]  c_wb_val,
    input  logic              c_memptr,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_ptr,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic              opnd_is_reg,
    output logic              opnd_is_imm,
    output logic [REG_W-1:0]  opnd_data,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [REG_W-1:0]  wb_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr
);
    import ea_pkg::*;

    ea_state_e state;

    // State machine and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            done        <= 1'b0;
            ea          <= '0;
            opnd_is_reg <= 1'b0;
            opnd_is_imm <= 1'b0;
            opnd_data   <= '0;
            wb_en       <= 1'b0;
            wb_idx      <= '0;
            wb_data     <= '0;
            rd_req      <= 1'b0;
            rd_addr     <= '0;
        end else begin
            done  <= 1'b0;
            wb_en <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && c_memptr) begin
                        state   <= ST_WAIT;
                        rd_req  <= 1'b1;
                        rd_addr <= {{(ADDR_W-8){1'b0}}, ptr_loc};
                    end else if (start) begin
                        done        <= 1'b1;
                        ea          <= c_ea;
                        opnd_is_reg <= c_is_reg;
                        opnd_is_imm <= c_is_imm;
                        opnd_data   <= c_opnd;
                        wb_en       <= c_wb;
                        wb_idx      <= idx;
                        wb_data     <= c_wb_val;
                    end
                end
                ST_WAIT: begin
                    if (rd_valid) begin
                        state       <= ST_IDLE;
                        rd_req      <= 1'b0;
                        done        <= 1'b1;
                        ea          <= rd_ptr;
                        opnd_is_reg <= 1'b0;
                        opnd_is_imm <= 1'b0;
                        opnd_data   <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ea_unit.sv
`timescale 1ns/1ps
// Effective address generation unit, top level.
// Connects the register view selector, the address arithmetic and the
// sequencer. The caller applies the write-back and serves pointer reads.
module ea_unit #(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 32,
    parameter int NREGS  = 8,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [3:0]             mode,
    input  logic [1:0]             size,
    input  logic [IDX_W:0]         reg_sel,
    input  logic [NREGS*REG_W-1:0] rf_flat,
    input  logic [ADDR_W-1:0]      pc,
    input  logic [REG_W-1:0]       ext,
    input  logic                   rd_valid,
    input  logic [REG_W-1:0]       rd_data,
    output logic                   done,
    output logic [ADDR_W-1:0]      ea,
    output logic                   opnd_is_reg,
    output logic                   opnd_is_imm,
    output logic [REG_W-1:0]       opnd_data,
    output logic                   wb_en,
    output logic [IDX_W-1:0]       wb_idx,
    output logic [REG_W-1:0]       wb_data,
    output logic                   rd_req,
    output logic [ADDR_W-1:0]      rd_addr
);
    logic [REG_W-1:0]  reg_full;
    logic [REG_W-1:0]  reg_view;
    logic [ADDR_W-1:0] c_ea;
    logic              c_is_reg;
    logic              c_is_imm;
    logic [REG_W-1:0]  c_opnd;
    logic              c_wb;
    logic [REG_W-1:0]  c_wb_val;
    logic              c_memptr;
    logic              ptr_hi_unused;

    assign ptr_hi_unused = ^rd_data[REG_W-1:ADDR_W];

    ea_reg_view #(.REG_W(REG_W), .NREGS(NREGS)) u_view (
        .rf_flat  (rf_flat),
        .sel      (reg_sel[IDX_W-1:0]),
        .half     (reg_sel[IDX_W]),
        .size     (size),
        .reg_full (reg_full),
        .reg_view (reg_view)
    );

    ea_addr_calc #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_calc (
        .mode     (mode),
        .size     (size),
        .reg_full (reg_full),
        .reg_view (reg_view),
        .pc       (pc),
        .ext      (ext),
        .c_ea     (c_ea),
        .c_is_reg (c_is_reg),
        .c_is_imm (c_is_imm),
        .c_opnd   (c_opnd),
        .c_wb     (c_wb),
        .c_wb_val (c_wb_val),
        .c_memptr (c_memptr)
    );

    ea_ctrl #(.ADDR_W(ADDR_W), .REG_W(REG_W), .IDX_W(IDX_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .idx         (reg_sel[IDX_W-1:0]),
        .ptr_loc     (ext[7:0]),
        .c_ea        (c_ea),
        .c_is_reg    (c_is_reg),
        .c_is_imm    (c_is_imm),
        .c_opnd      (c_opnd),
        .c_wb        (c_wb),
        .c_wb_val    (c_wb_val),
        .c_memptr    (c_memptr),
        .rd_valid    (rd_valid),
        .rd_ptr      (rd_data[ADDR_W-1:0]),
        .done        (done),
        .ea          (ea),
        .opnd_is_reg (opnd_is_reg),
        .opnd_is_imm (opnd_is_imm),
        .opnd_data   (opnd_data),
        .wb_en       (wb_en),
        .wb_idx      (wb_idx),
        .wb_data     (wb_data),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr)
    );

endmodule

// File: rtl/ea_unit_chk.sv
`timescale 1ns/1ps
// Protocol checker for ea_unit, attached by bind. It observes only the ports.
module ea_unit_chk #(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [3:0]        mode,
    input logic              rd_valid,
    input logic [REG_W-1:0]  rd_data,
    input logic              done,
    input logic [ADDR_W-1:0] ea,
    input logic              opnd_is_reg,
    input logic              opnd_is_imm,
    input logic              wb_en,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr
);
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(opnd_is_reg && opnd_is_imm)); // R7

    AST_PTR_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[ADDR_W-1:8] == '0)); // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr))); // R9

    AST_PTR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid) |=> (done && !rd_req && ea == $past(rd_data[ADDR_W-1:0]))); // R9

    AST_PTR_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !rd_req && mode == 4'd12) |=> (rd_req && !done)); // R9

    AST_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !rd_req && mode != 4'd12) |=> done); // R10

    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done); // R10

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> !done); // R11

endmodule

bind ea_unit ea_unit_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mode        (mode),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .done        (done),
    .ea          (ea),
    .opnd_is_reg (opnd_is_reg),
    .opnd_is_imm (opnd_is_imm),
    .wb_en       (wb_en),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr)
);

// File: tb/ea_unit_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected results, a monitor process
// pops and compares them whenever done is seen at a falling edge.
module ea_unit_test;

    typedef struct {
        string       tag;
        logic [23:0] ea;
        logic        isr;
        logic        isi;
        logic [31:0] data;
        logic        wb;
        logic [2:0]  widx;
        logic [31:0] wdat;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [3:0]   mode = '0;
    logic [1:0]   size = '0;
    logic [3:0]   reg_sel = '0;
    logic [255:0] rf_flat;
    logic [23:0]  pc = 24'h001234;
    logic [31:0]  ext = '0;
    logic         rd_valid = 1'b0;
    logic [31:0]  rd_data = '0;
    logic         done;
    logic [23:0]  ea;
    logic         opnd_is_reg;
    logic         opnd_is_imm;
    logic [31:0]  opnd_data;
    logic         wb_en;
    logic [2:0]   wb_idx;
    logic [31:0]  wb_data;
    logic         rd_req;
    logic [23:0]  rd_addr;

    logic [31:0] rf [8];
    exp_t        sbq [$];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 8; k++) rf_flat[k*32 +: 32] = rf[k];
    end

    ea_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .size(size),
        .reg_sel(reg_sel), .rf_flat(rf_flat), .pc(pc), .ext(ext),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .ea(ea),
        .opnd_is_reg(opnd_is_reg), .opnd_is_imm(opnd_is_imm),
        .opnd_data(opnd_data), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_data(wb_data), .rd_req(rd_req), .rd_addr(rd_addr)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Monitor: compare every done against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_chk++;
            if (sbq.size() == 0) begin
                n_bad++;
                $display("FAIL R11 unexpected done: actual=1 expected=0");
            end else begin
                exp_t e;
                bit ok;
                e = sbq.pop_front();
                ok = (ea == e.ea) && (opnd_is_reg == e.isr) && (opnd_is_imm == e.isi)
                     && (opnd_data == e.data) && (wb_en == e.wb)
                     && (!e.wb || (wb_idx == e.widx && wb_data == e.wdat));
                if (!ok) begin
                    n_bad++;
                    $display("FAIL %s: actual ea=%h reg=%b imm=%b data=%h wb=%b idx=%0d wdat=%h expected ea=%h reg=%b imm=%b data=%h wb=%b idx=%0d wdat=%h",
                             e.tag, ea, opnd_is_reg, opnd_is_imm, opnd_data, wb_en, wb_idx, wb_data,
                             e.ea, e.isr, e.isi, e.data, e.wb, e.widx, e.wdat);
                end
            end
        end
    end

    // Driver for single-cycle modes; also checks done timing (R10).
    task automatic op(input string tag, input logic [3:0] m, input logic [1:0] sz,
                      input logic [3:0] sel, input logic [31:0] x,
                      input logic [23:0] xea, input logic xr, input logic xi,
                      input logic [31:0] xd, input logic xw, input logic [31:0] xwd);
        exp_t e;
        e.tag = tag; e.ea = xea; e.isr = xr; e.isi = xi; e.data = xd;
        e.wb = xw; e.widx = sel[2:0]; e.wdat = xwd;
        @(negedge clk);
        mode = m; size = sz; reg_sel = sel; ext = x; start = 1'b1;
        sbq.push_back(e);
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b1, {"R10 done one cycle after start, ", tag}, {31'd0, done}, 32'd1);
        @(negedge clk);
        check(done === 1'b0, {"R10 done is a single pulse, ", tag}, {31'd0, done}, 32'd0);
    endtask

    // Driver for the pointer mode with a stray start during the wait (R9, R11).
    task automatic ptr_op(input logic [31:0] x, input int waitc, input logic [31:0] rdat);
        exp_t e;
        e.tag = "R9 pointer result"; e.ea = rdat[23:0]; e.isr = 1'b0; e.isi = 1'b0;
        e.data = '0; e.wb = 1'b0; e.widx = '0; e.wdat = '0;
        @(negedge clk);
        mode = 4'd12; ext = x; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(rd_req === 1'b1, "R9 request one cycle after start", {31'd0, rd_req}, 32'd1);
        check(rd_addr == {16'd0, x[7:0]}, "R9 pointer address zero-extended", {8'd0, rd_addr}, {24'd0, x[7:0]});
        for (int i = 0; i < waitc; i++) begin
            mode = 4'd1; reg_sel = 4'd0; start = (i == 1);
            @(negedge clk);
            check(rd_req === 1'b1, "R9 request held while waiting", {31'd0, rd_req}, 32'd1);
            check(done === 1'b0, "R11 no done while waiting", {31'd0, done}, 32'd0);
        end
        start = 1'b0;
        rd_valid = 1'b1; rd_data = rdat;
        sbq.push_back(e);
        @(negedge clk);
        rd_valid = 1'b0; rd_data = 32'hFFFF_FFFF;
        check(rd_req === 1'b0, "R9 request dropped after response", {31'd0, rd_req}, 32'd0);
        @(negedge clk);
        check(ea == rdat[23:0], "R11 result kept after stray start", {8'd0, ea}, {8'd0, rdat[23:0]});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rf[0] = 32'hA1B2C3D4; rf[1] = 32'h00001000; rf[2] = 32'h00FFFFFF;
        rf[3] = 32'h7F000010; rf[4] = 32'h44444444; rf[5] = 32'h00000000;
        rf[6] = 32'h66666666; rf[7] = 32'h77777777;
        repeat (3) @(negedge clk);
        check(done === 1'b0 && rd_req === 1'b0 && wb_en === 1'b0, "R12 control outputs low in reset",
              {29'd0, done, rd_req, wb_en}, 32'd0);
        check(ea === 24'd0, "R12 address zero in reset", {8'd0, ea}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done === 1'b0 && ea === 24'd0, "R12 idle after reset", {7'd0, done, ea}, 32'd0);

        // R1 register views
        op("R1 byte high",  4'd0, 2'd0, 4'b0000, 32'd0, 24'd0, 1, 0, 32'h000000C3, 0, 0);
        op("R1 byte low",   4'd0, 2'd0, 4'b1000, 32'd0, 24'd0, 1, 0, 32'h000000D4, 0, 0);
        op("R1 word low",   4'd0, 2'd1, 4'b0000, 32'd0, 24'd0, 1, 0, 32'h0000C3D4, 0, 0);
        op("R1 word upper", 4'd0, 2'd1, 4'b1000, 32'd0, 24'd0, 1, 0, 32'h0000A1B2, 0, 0);
        op("R1 long",       4'd0, 2'd2, 4'b0000, 32'd0, 24'd0, 1, 0, 32'hA1B2C3D4, 0, 0);
        // R2 register indirect
        op("R2 indirect",   4'd1, 2'd2, 4'd0, 32'd0, 24'hB2C3D4, 0, 0, 32'd0, 0, 0);
        // R3 displacement
        op("R3 disp16 negative", 4'd2, 2'd0, 4'd1, 32'h0000FFF0, 24'h000FF0, 0, 0, 32'd0, 0, 0);
        op("R3 disp16 positive", 4'd2, 2'd0, 4'd1, 32'hFFFF7FFF, 24'h008FFF, 0, 0, 32'd0, 0, 0);
        op("R3 disp24 wrap",     4'd3, 2'd0, 4'd2, 32'hAA000002, 24'h000001, 0, 0, 32'd0, 0, 0);
        // R4 post-increment
        op("R4 postinc long", 4'd4, 2'd2, 4'd3, 32'd0, 24'h000010, 0, 0, 32'd0, 1, 32'h7F000014);
        op("R4 postinc byte", 4'd4, 2'd0, 4'd3, 32'd0, 24'h000010, 0, 0, 32'd0, 1, 32'h7F000011);
        op("R4 postinc word carry", 4'd4, 2'd1, 4'd2, 32'd0, 24'hFFFFFF, 0, 0, 32'd0, 1, 32'h01000001);
        // R5 pre-decrement
        op("R5 predec word from zero", 4'd5, 2'd1, 4'd5, 32'd0, 24'hFFFFFE, 0, 0, 32'd0, 1, 32'hFFFFFFFE);
        op("R5 predec long",  4'd5, 2'd2, 4'd1, 32'd0, 24'h000FFC, 0, 0, 32'd0, 1, 32'h00000FFC);
        // R6 absolute
        op("R6 abs8 top page", 4'd6, 2'd0, 4'd0, 32'h00000012, 24'hFFFF12, 0, 0, 32'd0, 0, 0);
        op("R6 abs16 negative", 4'd7, 2'd0, 4'd0, 32'h00008000, 24'hFF8000, 0, 0, 32'd0, 0, 0);
        op("R6 abs16 positive", 4'd7, 2'd0, 4'd0, 32'hAB001234, 24'h001234, 0, 0, 32'd0, 0, 0);
        op("R6 abs24",          4'd8, 2'd0, 4'd0, 32'h55ABCDEF, 24'hABCDEF, 0, 0, 32'd0, 0, 0);
        // R7 immediate
        op("R7 imm byte", 4'd9, 2'd0, 4'd0, 32'h12345678, 24'd0, 0, 1, 32'h00000078, 0, 0);
        op("R7 imm word", 4'd9, 2'd1, 4'd0, 32'h12345678, 24'd0, 0, 1, 32'h00005678, 0, 0);
        op("R7 imm long", 4'd9, 2'd2, 4'd0, 32'h12345678, 24'd0, 0, 1, 32'h12345678, 0, 0);
        // R8 PC-relative
        op("R8 pcrel8 negative", 4'd10, 2'd0, 4'd0, 32'h00000080, 24'h0011B4, 0, 0, 32'd0, 0, 0);
        op("R8 pcrel8 positive", 4'd10, 2'd0, 4'd0, 32'h0000007F, 24'h0012B3, 0, 0, 32'd0, 0, 0);
        op("R8 pcrel16 negative", 4'd11, 2'd0, 4'd0, 32'h0000F000, 24'h000234, 0, 0, 32'd0, 0, 0);
        pc = 24'h000010;
        op("R8 pcrel16 wrap", 4'd11, 2'd0, 4'd0, 32'h00008000, 24'hFF8010, 0, 0, 32'd0, 0, 0);
        // R13 unused mode codes
        op("R13 unused code 13", 4'd13, 2'd2, 4'd3, 32'h12345678, 24'd0, 0, 0, 32'd0, 0, 0);
        op("R13 unused code 15", 4'd15, 2'd0, 4'd1, 32'hFFFFFFFF, 24'd0, 0, 0, 32'd0, 0, 0);
        // R9 and R11 pointer mode
        ptr_op(32'hFFFFFF80, 4, 32'hDEADBEEF);
        ptr_op(32'h000000FF, 0, 32'h00123456);

        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R10 every expected result produced", sbq.size(), 32'd0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule